// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Sequencer

This block is a bus master that performs one indivisible read-modify-write operand access on an asynchronous 32-bit bus. It serves semaphore operations: test-and-set, compare-and-swap and unconditional swap. The core hands over one request with the address, function code, operand size, operation type, a cache-inhibit bit, a compare value and an update value. The sequencer runs a read cycle and decides from the data read whether a write cycle follows. If a write is due it runs that write cycle. A lock output stays asserted for the whole sequence, and the block holds back any bus grant until the sequence is over.

The block is clocked at twice the bus clock, so each state lasts one half bus clock. The read states are named `ST_RD_S0`, `ST_RD_S1`, `ST_RD_WAIT` and `ST_RD_END`. The write states are `ST_WR_S0`, `ST_WR_S1`, `ST_WR_WAIT` and `ST_WR_END`. The block idles in `ST_IDLE` and reports in `ST_DONE`. The transitions are:
- IDLE→RD_S0 on an accepted request.
- RD_S0→RD_S1→RD_WAIT, with RD_WAIT holding until acknowledge.
- RD_WAIT→RD_END.
- RD_END→WR_S0 when a write is due, or RD_END→DONE when it is not.
- WR_S0→WR_S1→WR_WAIT, with WR_WAIT holding until acknowledge.
- WR_WAIT→WR_END→DONE.
- DONE→IDLE.

When the sequence ends, the core gets a one-cycle done pulse together with the data read and a flag that says whether a write took place.

Top module: `rmw_seq`

## Requirements
- R1: `bus_lock` is high in every state from `ST_RD_S0` through `ST_WR_END` (or `ST_RD_END` when no write follows). It falls in the cycle where `done` is high, and `bus_as` is never high without `bus_lock`.
- R2: `bus_bg` is never high while `bus_lock` is high. In idle with `bus_br` high, `bus_bg` rises one cycle later, and while `bus_bg` is high `req_ready` is low.
- R3: During the read cycle `cache_miss_force` is high, and `bus_ci` equals the request's cache-inhibit bit.
- R4: For compare-and-swap (op 2'b01), the write happens only when the read data equals the compare value under the size mask. The masks are: size 0 = byte, bits 7:0; size 1 = word, bits 15:0; size 2 or 3 = long, all 32 bits. When the compare fails, the sequence ends with no write cycle and `wrote` low.
- R5: In `ST_RD_S0` the block asserts `bus_ecs`, `bus_ocs` and `bus_lock`. It drives address, function code and size from the request, holds `bus_rw` high, and keeps `bus_as` and `bus_ds` low.
- R6: One state after a cycle-start state, `bus_as` is asserted and `bus_ecs`/`bus_ocs` are low. In a read, `bus_ds` rises together with `bus_as`.
- R7: While `bus_as` and `bus_ds` are high and `bus_dack` is low, the cycle stays open. The read data is the `bus_din` value presented with `bus_dack`.
- R8: Test-and-set (op 2'b00) always writes. The write data is the read data with the top bit of the operand size set: bit 7, bit 15 or bit 31.
- R9: Between the read and the write cycle, `bus_as` and `bus_ds` are low for at least one state while `bus_lock` stays high.
- R10: In a write cycle, `bus_rw` is low in the state before `bus_as` rises. `bus_ds` rises one state after `bus_as`, with `bus_dout` already carrying the write data.
- R11: `done` is a one-cycle pulse carrying `rd_data` and `wrote`. `req_ready` is high only in idle while the bus is not granted.
- R12: Swap (op 2'b10 or 2'b11) always writes the update value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate; one state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe from the core |
| req_ready | output | 1 | Sequencer idle and bus owned |
| req_addr | input | AW | Operand address |
| req_fc | input | FCW | Function code |
| req_size | input | 2 | Operand size (0 byte, 1 word, 2/3 long) |
| req_op | input | 2 | 00 test-and-set, 01 compare-and-swap, 1x swap |
| req_ci | input | 1 | Cache-inhibit bit from translation |
| req_cmp | input | DW | Compare value |
| req_upd | input | DW | Update value |
| bus_addr | output | AW | Address bus |
| bus_fc | output | FCW | Function code bus |
| bus_size | output | 2 | Size bus |
| bus_rw | output | 1 | High read, low write |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| bus_ecs | output | 1 | External cycle-start strobe |
| bus_ocs | output | 1 | Operand cycle-start strobe |
| bus_lock | output | 1 | Indivisible-sequence indicator |
| bus_ci | output | 1 | Cache-inhibit out during the read |
| cache_miss_force | output | 1 | Forces the read to miss the data cache |
| bus_dout | output | DW | Write data |
| bus_din | input | DW | Read data |
| bus_dack | input | 1 | Data acknowledge |
| bus_br | input | 1 | External bus request |
| bus_bg | output | 1 | Bus grant |
| done | output | 1 | Sequence complete pulse |
| rd_data | output | DW | Value read |
| wrote | output | 1 | Write cycle took place |

## Verification
Some protocol rules are checked on every cycle. These are lock coverage of every strobe, grant suppression under lock, the strobe order of the cycle-start and write states, the strobe gap between read and write, cycles held open without acknowledge, and the one-cycle done pulse. Other behaviour only the bench scenarios can show. That covers the data decisions: compare success or failure under each size mask, the test-and-set bit position, swap data, and the read value returned. It also covers the values actually driven on address, function code and cache-inhibit, and the grant handover around an idle request.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_S0,
        ST_RD_S1,
        ST_RD_WAIT,
        ST_RD_END,
        ST_WR_S0,
        ST_WR_S1,
        ST_WR_WAIT,
        ST_WR_END,
        ST_DONE
    } rmw_state_t;

    localparam logic [1:0] OP_TAS  = 2'b00;
    localparam logic [1:0] OP_CAS  = 2'b01;
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
endpackage

// File: rtl/rmw_modify.sv
module rmw_modify
    import rmw_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    op,
    input  logic [1:0]    size,
    input  logic [DW-1:0] rd,
    input  logic [DW-1:0] cmp,
    input  logic [DW-1:0] upd,
    output logic          do_write,
    output logic [DW-1:0] wdata
);
    localparam int BYTE_MSB = 7;
    localparam int WORD_MSB = 15;
    localparam int LONG_MSB = DW - 1;

    logic [DW-1:0] mask;
    logic [DW-1:0] top;

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            if (size == SZ_BYTE)      mask[i] = (i <= BYTE_MSB);
            else if (size == SZ_WORD) mask[i] = (i <= WORD_MSB);
            else                      mask[i] = 1'b1;
        end
        top = '0;
        if (size == SZ_BYTE)      top[BYTE_MSB] = 1'b1;
        else if (size == SZ_WORD) top[WORD_MSB] = 1'b1;
        else                      top[LONG_MSB] = 1'b1;
    end

    always_comb begin
        if (op == OP_TAS) begin
            do_write = 1'b1;
            wdata    = rd | top;
        end else if (op == OP_CAS) begin
            do_write = ((rd & mask) == (cmp & mask));
            wdata    = upd;
        end else begin
            do_write = 1'b1;
            wdata    = upd;
        end
    end
endmodule

// File: rtl/rmw_grant.sv
module rmw_grant (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic start,
    input  logic br,
    output logic bg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bg <= 1'b0;
        else        bg <= idle && !start && br;
    end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
    import rmw_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int FCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [AW-1:0]  req_addr,
    input  logic [FCW-1:0] req_fc,
    input  logic [1:0]     req_size,
    input  logic [1:0]     req_op,
    input  logic           req_ci,
    input  logic [DW-1:0]  req_cmp,
    input  logic [DW-1:0]  req_upd,
    output logic [AW-1:0]  bus_addr,
    output logic [FCW-1:0] bus_fc,
    output logic [1:0]     bus_size,
    output logic           bus_rw,
    output logic           bus_as,
    output logic           bus_ds,
    output logic           bus_ecs,
    output logic           bus_ocs,
    output logic           bus_lock,
    output logic           bus_ci,
    output logic           cache_miss_force,
    output logic [DW-1:0]  bus_dout,
    input  logic [DW-1:0]  bus_din,
    input  logic           bus_dack,
    input  logic           bus_br,
    output logic           bus_bg,
    output logic           done,
    output logic [DW-1:0]  rd_data,
    output logic           wrote
);
    rmw_state_t     state_q, state_d;
    logic [AW-1:0]  addr_q;
    logic [FCW-1:0] fc_q;
    logic [1:0]     size_q, op_q;
    logic           ci_q, wrote_q;
    logic [DW-1:0]  cmp_q, upd_q, rd_q, wdata_q;
    logic           start, idle, do_write;
    logic [DW-1:0]  wdata_c;

    assign idle      = (state_q == ST_IDLE);
    assign req_ready = idle && !bus_bg;
    assign start     = req_valid && req_ready;

    rmw_modify #(.DW(DW)) u_mod (
        .op(op_q), .size(size_q), .rd(rd_q), .cmp(cmp_q), .upd(upd_q),
        .do_write(do_write), .wdata(wdata_c)
    );

    rmw_grant u_grant (
        .clk(clk), .rst_n(rst_n), .idle(idle), .start(start),
        .br(bus_br), .bg(bus_bg)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_RD_S0;
            ST_RD_S0:   state_d = ST_RD_S1;
            ST_RD_S1:   state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (bus_dack) state_d = ST_RD_END;
            ST_RD_END:  state_d = do_write ? ST_WR_S0 : ST_DONE;
            ST_WR_S0:   state_d = ST_WR_S1;
            ST_WR_S1:   state_d = ST_WR_WAIT;
            ST_WR_WAIT: if (bus_dack) state_d = ST_WR_END;
            ST_WR_END:  state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            fc_q    <= '0;
            size_q  <= '0;
            op_q    <= '0;
            ci_q    <= 1'b0;
            cmp_q   <= '0;
            upd_q   <= '0;
            rd_q    <= '0;
            wdata_q <= '0;
            wrote_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                addr_q  <= req_addr;
                fc_q    <= req_fc;
                size_q  <= req_size;
                op_q    <= req_op;
                ci_q    <= req_ci;
                cmp_q   <= req_cmp;
                upd_q   <= req_upd;
                wrote_q <= 1'b0;
            end
            if (state_q == ST_RD_WAIT && bus_dack) rd_q <= bus_din;
            if (state_q == ST_RD_END) begin
                wrote_q <= do_write;
                wdata_q <= wdata_c;
            end
        end
    end

    always_comb begin
        bus_rw           = 1'b1;
        bus_as           = 1'b0;
        bus_ds           = 1'b0;
        bus_ecs          = 1'b0;
        bus_ocs          = 1'b0;
        bus_lock         = 1'b0;
        bus_ci           = 1'b0;
        cache_miss_force = 1'b0;
        bus_dout         = '0;
        unique case (state_q)
            ST_RD_S0: begin
                bus_ecs = 1'b1; bus_ocs = 1'b1; bus_lock = 1'b1;
                bus_ci = ci_q; cache_miss_force = 1'b1;
            end
            ST_RD_S1, ST_RD_WAIT: begin
                bus_as = 1'b1; bus_ds = 1'b1; bus_lock = 1'b1;
                bus_ci = ci_q; cache_miss_force = 1'b1;
            end
            ST_RD_END: bus_lock = 1'b1;
            ST_WR_S0: begin
                bus_ecs = 1'b1; bus_ocs = 1'b1; bus_lock = 1'b1;
                bus_rw = 1'b0; bus_dout = wdata_q;
            end
            ST_WR_S1: begin
                bus_as = 1'b1; bus_lock = 1'b1;
                bus_rw = 1'b0; bus_dout = wdata_q;
            end
            ST_WR_WAIT: begin
                bus_as = 1'b1; bus_ds = 1'b1; bus_lock = 1'b1;
                bus_rw = 1'b0; bus_dout = wdata_q;
            end
            ST_WR_END: begin
                bus_lock = 1'b1; bus_rw = 1'b0; bus_dout = wdata_q;
            end
            default: ;
        endcase
    end

    assign bus_addr = idle ? '0 : addr_q;
    assign bus_fc   = idle ? '0 : fc_q;
    assign bus_size = idle ? '0 : size_q;
    assign done     = (state_q == ST_DONE);
    assign rd_data  = rd_q;
    assign wrote    = wrote_q;
endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic bus_rw,
    input logic bus_as,
    input logic bus_ds,
    input logic bus_ecs,
    input logic bus_ocs,
    input logic bus_lock,
    input logic cache_miss_force,
    input logic bus_dack,
    input logic bus_bg,
    input logic done
);
    a_r1_as_locked: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |-> bus_lock);
    a_r1_lock_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_lock) |-> done);
    a_r2_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |-> !bus_bg);
    a_r2_grant_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        bus_bg |-> !req_ready);
    a_r3_force_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as && bus_rw) |-> cache_miss_force);
    a_r5_start_state: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ecs |-> (bus_ocs && bus_lock && !bus_as && !bus_ds));
    a_r6_strobe_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_as) |-> ($past(bus_ecs) && !bus_ecs && !bus_ocs));
    a_r7_hold_open: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as && bus_ds && !bus_dack) |=> bus_as);
    a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_as) && bus_lock) |=> (!bus_as && !bus_ds));
    a_r10_rw_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_as) && !bus_rw) |-> !$past(bus_rw));
    a_r10_ds_late: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_ds) && !bus_rw) |-> $past(bus_as));
    a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_done_free: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_lock && !bus_as && !req_ready));
endmodule

bind rmw_seq rmw_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_rw(bus_rw),
    .bus_as(bus_as), .bus_ds(bus_ds), .bus_ecs(bus_ecs), .bus_ocs(bus_ocs),
    .bus_lock(bus_lock), .cache_miss_force(cache_miss_force),
    .bus_dack(bus_dack), .bus_bg(bus_bg), .done(done)
);

// File: tb/sim_rmw_seq.sv
`timescale 1ns/1ps
module sim_rmw_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_fc = '0;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_op = '0;
    logic        req_ci = 1'b0;
    logic [31:0] req_cmp = '0;
    logic [31:0] req_upd = '0;
    logic [31:0] bus_addr;
    logic [2:0]  bus_fc;
    logic [1:0]  bus_size;
    logic        bus_rw, bus_as, bus_ds, bus_ecs, bus_ocs, bus_lock, bus_ci;
    logic        cache_miss_force;
    logic [31:0] bus_dout;
    logic [31:0] bus_din = '0;
    logic        bus_dack = 1'b0;
    logic        bus_br = 1'b0;
    logic        bus_bg, done, wrote;
    logic [31:0] rd_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [31:0] sl_mem = '0;
    int          sl_wait = 0;
    int          sl_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] wr_data = '0;
    logic        rd_ci = 1'b0;
    logic        rd_miss = 1'b0;

    always #10 clk = ~clk;

    rmw_seq u0 (.*);

    always @(negedge clk) begin
        if (bus_as && bus_ds) begin
            if (!bus_dack) begin
                if (sl_cnt >= sl_wait) begin
                    bus_dack = 1'b1;
                    if (bus_rw) begin
                        bus_din = sl_mem;
                        rd_ci   = bus_ci;
                        rd_miss = cache_miss_force;
                    end else begin
                        wr_cnt  = wr_cnt + 1;
                        wr_data = bus_dout;
                    end
                end else sl_cnt = sl_cnt + 1;
            end
        end else begin
            bus_dack = 1'b0;
            sl_cnt   = 0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] e_mask(input logic [1:0] s);
        if (s == 2'd0) return 32'h0000_00FF;
        if (s == 2'd1) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] e_top(input logic [1:0] s);
        if (s == 2'd0) return 32'h0000_0080;
        if (s == 2'd1) return 32'h0000_8000;
        return 32'h8000_0000;
    endfunction

    function automatic bit e_wr(input logic [1:0] op, input logic [31:0] rd, input logic [31:0] cmp, input logic [1:0] s);
        if (op == 2'b01) return ((rd & e_mask(s)) == (cmp & e_mask(s)));
        return 1'b1;
    endfunction

    function automatic logic [31:0] e_wd(input logic [1:0] op, input logic [31:0] rd, input logic [31:0] upd, input logic [1:0] s);
        if (op == 2'b00) return rd | e_top(s);
        return upd;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [1:0] sz, input bit ci,
                          input logic [31:0] addr, input logic [2:0] fc,
                          input logic [31:0] mem, input logic [31:0] cmp,
                          input logic [31:0] upd, input int wt, input bit br_noise);
        int   w0;
        int   n;
        bit   lock_ok, bg_ok, gap_ok, rwfirst_ok;
        logic prev_as, prev_rw, prev_lock;
        logic [31:0] dout_at_ds;
        bit   ds_data_ok;
        bit   ew;
        sl_mem  = mem;
        sl_wait = wt;
        n = 0;
        while (!req_ready && n < 50) begin @(negedge clk); n++; end
        w0 = wr_cnt;
        req_addr = addr; req_fc = fc; req_size = sz; req_op = op;
        req_ci = ci; req_cmp = cmp; req_upd = upd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R5: first state after acceptance
        check(bus_ecs && bus_ocs && bus_lock && bus_rw && !bus_as && !bus_ds &&
              bus_addr == addr && bus_fc == fc && bus_size == sz,
              "R5 start state", bus_addr, addr);
        @(negedge clk);
        // R6: strobes one state later
        check(bus_as && bus_ds && !bus_ecs && !bus_ocs, "R6 strobes", {28'd0, bus_as, bus_ds, bus_ecs, bus_ocs}, 32'hC);
        lock_ok = 1; bg_ok = 1; gap_ok = 1; rwfirst_ok = 1; ds_data_ok = 1;
        prev_as = bus_as; prev_rw = bus_rw; prev_lock = bus_lock;
        ew = e_wr(op, mem, cmp, sz);
        n = 0;
        while (!done && n < 200) begin
            if (br_noise) bus_br = $urandom_range(0, 1);
            @(negedge clk);
            n++;
            if (!done && !bus_lock) lock_ok = 0;
            if (bus_lock && bus_bg) bg_ok = 0;
            if (bus_as && !prev_as && !bus_rw && prev_rw) rwfirst_ok = 0;
            if (bus_as && !prev_as && !bus_rw && prev_lock && prev_as) gap_ok = 0;
            if (bus_ds && !bus_rw && bus_dout != e_wd(op, mem, upd, sz)) ds_data_ok = 0;
            prev_as = bus_as; prev_rw = bus_rw; prev_lock = bus_lock;
        end
        bus_br = 1'b0;
        check(done, "R11 done seen", {31'd0, done}, 32'd1);
        check(lock_ok, "R1 lock held", {31'd0, lock_ok}, 32'd1);
        check(bg_ok, "R2 grant under lock", {31'd0, bg_ok}, 32'd1);
        check(rd_data == mem, "R7 read data", rd_data, mem);
        check(rd_ci == ci && rd_miss, "R3 ci and miss", {30'd0, rd_ci, rd_miss}, {30'd0, ci, 1'b1});
        check(wrote == ew, "R4 R8 R12 wrote flag", {31'd0, wrote}, {31'd0, ew});
        check((wr_cnt - w0) == (ew ? 1 : 0), "R4 write cycles", wr_cnt - w0, ew ? 1 : 0);
        if (ew) check(wr_data == e_wd(op, mem, upd, sz), "R8 R12 write data", wr_data, e_wd(op, mem, upd, sz));
        check(rwfirst_ok && gap_ok && ds_data_ok, "R9 R10 write cycle order",
              {29'd0, rwfirst_ok, gap_ok, ds_data_ok}, 32'd7);
        @(negedge clk);
        check(!done && !bus_lock, "R11 done pulse", {30'd0, done, bus_lock}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!bus_lock && !bus_as && !bus_bg && !done, "R1 reset state",
              {28'd0, bus_lock, bus_as, bus_bg, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R11 ready after reset", {31'd0, req_ready}, 32'd1);
        // R2: grant in idle blocks acceptance
        bus_br = 1'b1;
        @(negedge clk);
        check(bus_bg && !req_ready, "R2 grant while idle", {30'd0, bus_bg, req_ready}, 32'd2);
        req_valid = 1'b1;
        repeat (2) @(negedge clk);
        check(!bus_lock && bus_bg, "R2 request held off", {30'd0, bus_lock, bus_bg}, 32'd1);
        req_valid = 1'b0;
        bus_br = 1'b0;
        @(negedge clk);
        check(!bus_bg && req_ready, "R11 ready after release", {30'd0, bus_bg, req_ready}, 32'd1);
        // directed corner cases
        run_op(2'b01, 2'd2, 1'b0, 32'h1000, 3'd5, 32'hCAFE_0001, 32'hCAFE_0001, 32'h1111_2222, 0, 1'b0);
        run_op(2'b01, 2'd2, 1'b1, 32'h1004, 3'd5, 32'hCAFE_0001, 32'hCAFE_0002, 32'h1111_2222, 3, 1'b0);
        run_op(2'b01, 2'd1, 1'b0, 32'h1008, 3'd1, 32'hAAAA_1234, 32'h5555_1234, 32'h0000_7777, 1, 1'b0);
        run_op(2'b01, 2'd0, 1'b0, 32'h100C, 3'd1, 32'h0000_12FF, 32'h0000_34FE, 32'h0000_0001, 2, 1'b0);
        run_op(2'b00, 2'd0, 1'b1, 32'h2000, 3'd5, 32'h0000_0080, 32'h0, 32'h0, 0, 1'b1);
        run_op(2'b00, 2'd1, 1'b0, 32'h2002, 3'd5, 32'h0000_0001, 32'h0, 32'h0, 5, 1'b1);
        run_op(2'b00, 2'd2, 1'b0, 32'h2004, 3'd5, 32'h1234_5678, 32'h0, 32'h0, 0, 1'b0);
        run_op(2'b10, 2'd2, 1'b1, 32'h3000, 3'd6, 32'hDEAD_BEEF, 32'h0, 32'h0BAD_F00D, 4, 1'b1);
        run_op(2'b11, 2'd3, 1'b0, 32'h3004, 3'd6, 32'h0, 32'h1, 32'h5A5A_5A5A, 0, 1'b0);
        // constrained random
        for (int k = 0; k < 60; k++) begin
            logic [1:0]  op;
            logic [31:0] mem;
            logic [31:0] cmp;
            op  = 2'($urandom_range(0, 3));
            mem = $urandom;
            cmp = $urandom_range(0, 1) ? mem : $urandom;
            run_op(op, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                   $urandom, 3'($urandom_range(0, 7)), mem, cmp, $urandom,
                   $urandom_range(0, 6), 1'($urandom_range(0, 1)));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule